// File: doc/BRIEF.md
# Three-Frame Sub-Pixel Dither Modulator

This block turns a stored 4-bit pixel code into two on/off drive bits per internal scan frame. One bit is for a red sub-pixel and one is for a green sub-pixel. Each colour has a 2-bit intensity level. Those levels give four brightness steps: dark, lit in one frame of every three, lit in two frames of every three, and lit in every frame. Red and green are modulated independently, so the sixteen codes cover black, full yellow and every red/green mix between them.

A small control section keeps a frame phase that runs 0, 1, 2 and back to 0. It steps once for each internal frame-start strobe. These internal frames have no fixed relation to incoming video frames. A datapath section decodes each colour's level and picks the lit pattern for the current phase. The scan logic presents each stored pixel with a valid flag, and the outputs stay dark whenever that flag is low.

Top module: `tri_frame_dither`

## Requirements
- R1: After reset the frame phase is 0, so a code whose red and green levels are both 01 drives both outputs high before any frame strobe.
- R2: Bits [3:2] of the pixel code are the red level and drive `redOn`. Bits [1:0] are the green level and drive `greenOn`. The two colours never affect each other.
- R3: Level 00 keeps its output low in every phase.
- R4: Level 11 keeps its output high in every phase while the pixel is valid.
- R5: Level 01 is high only in phase 0.
- R6: Level 10 is high in phases 0 and 1 and low in phase 2.
- R7: The phase steps 0→1→2→0 once for each cycle in which `frameStart` is high. In every other cycle it holds its value.
- R8: While `pixValid` is low, both outputs are low. A frame strobe arriving during that time still advances the phase.
- R9: In the cycle that carries `frameStart`, the outputs follow the phase from before the step. The new phase shows from the next cycle on.
- R10: Over any three consecutive frames, the number of frames in which an output is high equals its level: 0, 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; clears the phase to 0 |
| frameStart | input | 1 | One-cycle strobe at the start of each internal scan frame |
| pixCode | input | 4 | Pixel code: [3:2] red level, [1:0] green level |
| pixValid | input | 1 | High when `pixCode` holds a real pixel |
| redOn | output | 1 | Red sub-pixel drive for the current frame |
| greenOn | output | 1 | Green sub-pixel drive for the current frame |

## Verification
The phase step and the level decode can happen in the same cycle. That occurs when a frame strobe arrives while a pixel is being evaluated. The bench provokes it by raising `frameStart` together with a one-third code while the phase is 0. It expects the output to stay lit through that cycle and to go dark in the following one. The bench also sends a strobe while `pixValid` is low. It then shows that the phase still moved, by presenting a valid one-third code afterwards.

// File: rtl/dither_pkg.sv
package dither_pkg;
  localparam int LEVEL_W   = 2;
  localparam int NUM_PHASE = 3;
  localparam int PHASE_W   = $clog2(NUM_PHASE);

  typedef enum logic [LEVEL_W-1:0] {
    LVL_OFF        = 2'b00,
    LVL_THIRD      = 2'b01,
    LVL_TWO_THIRDS = 2'b10,
    LVL_FULL       = 2'b11
  } level_e;

  // one-hot view of the frame phase handed from control to datapath
  typedef struct packed {
    logic first;
    logic second;
    logic third;
  } phase_strb_t;
endpackage

// File: rtl/dither_phase_ctrl.sv
module dither_phase_ctrl
  import dither_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  output phase_strb_t strb
);
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] phaseNext;
  logic               lastPhase;

  always_comb begin
    lastPhase = (phase == PHASE_W'(NUM_PHASE - 1));
    if (frameStart) phaseNext = lastPhase ? '0 : phase + 1'b1;
    else            phaseNext = phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else       phase <= phaseNext;
  end

  always_comb begin
    strb.first  = (phase == PHASE_W'(0));
    strb.second = (phase == PHASE_W'(1));
    strb.third  = (phase == PHASE_W'(2));
  end

  // R7: phase never leaves 0..2
  p_phase_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    phase < PHASE_W'(NUM_PHASE));

  // R7: no strobe, no movement
  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(phase));

  // R7: from the last phase a strobe returns to the first
  p_phase_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && strb.third) |=> strb.first);

  // R7: a strobe always changes the phase
  p_phase_moves_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !$stable(phase));
endmodule

// File: rtl/dither_level_dp.sv
module dither_level_dp
  import dither_pkg::*;
#(
  parameter  int NUM_CHAN = 2,
  localparam int CODE_W   = NUM_CHAN * LEVEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  phase_strb_t         strb,
  input  logic [CODE_W-1:0]   code,
  input  logic                valid,
  output logic [NUM_CHAN-1:0] lit
);
  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    level_e lvl;
    logic   pattern;

    assign lvl = level_e'(code[ch*LEVEL_W +: LEVEL_W]);

    always_comb begin
      unique case (lvl)
        LVL_OFF:        pattern = 1'b0;
        LVL_THIRD:      pattern = strb.first;
        LVL_TWO_THIRDS: pattern = strb.first | strb.second;
        default:        pattern = 1'b1;
      endcase
      lit[ch] = valid & pattern;
    end

    // R3: level 00 stays dark
    p_off_dark_r3: assert property (@(posedge clk) disable iff (!rstN)
      (lvl == LVL_OFF) |-> !lit[ch]);

    // R4: level 11 with a valid pixel is lit
    p_full_lit_r4: assert property (@(posedge clk) disable iff (!rstN)
      (valid && lvl == LVL_FULL) |-> lit[ch]);

    // R5: level 01 is dark outside phase 0
    p_third_dark_r5: assert property (@(posedge clk) disable iff (!rstN)
      (lvl == LVL_THIRD && !strb.first) |-> !lit[ch]);

    // R6: level 10 is dark in phase 2
    p_two_dark_r6: assert property (@(posedge clk) disable iff (!rstN)
      (lvl == LVL_TWO_THIRDS && strb.third) |-> !lit[ch]);
  end

  // R7: exactly one phase strobe from the control section
  p_strb_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strb) == 1);

  // R8: invalid pixel leaves every output dark
  p_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> (lit == '0));
endmodule

// File: rtl/tri_frame_dither.sv
module tri_frame_dither
  import dither_pkg::*;
#(
  parameter bit OUT_REG = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   frameStart,
  input  logic [2*LEVEL_W-1:0]   pixCode,
  input  logic                   pixValid,
  output logic                   redOn,
  output logic                   greenOn
);
  localparam int NUM_CHAN = 2;

  phase_strb_t         strb;
  logic [NUM_CHAN-1:0] lit;

  dither_phase_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .strb       (strb)
  );

  dither_level_dp #(.NUM_CHAN(NUM_CHAN)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .code  (pixCode),
    .valid (pixValid),
    .lit   (lit)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        redOn   <= 1'b0;
        greenOn <= 1'b0;
      end else begin
        redOn   <= lit[1];
        greenOn <= lit[0];
      end
    end
  end else begin : g_comb
    assign redOn   = lit[1];
    assign greenOn = lit[0];
  end
endmodule

// File: tb/tri_frame_dither_tb.sv
module tri_frame_dither_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0;
  logic       pixValid = 1'b0;
  logic [3:0] pixCode = 4'b0000;
  logic       redOn, greenOn;

  int total = 0;
  int bad = 0;
  int expPhase = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tri_frame_dither u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .pixCode(pixCode), .pixValid(pixValid),
    .redOn(redOn), .greenOn(greenOn)
  );

  function automatic logic expLit(logic [1:0] lv, int ph);
    case (lv)
      2'b00:   return 1'b0;
      2'b01:   return ph == 0;
      2'b10:   return ph != 2;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s phase=%0d code=%b actual=%b expected=%b",
               req, expPhase, pixCode, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] c, logic v);
    @(negedge clk);
    pixCode  = c;
    pixValid = v;
    #1;
  endtask

  task automatic checkPix(string req);
    chk(req, redOn,   pixValid ? expLit(pixCode[3:2], expPhase) : 1'b0);
    chk(req, greenOn, pixValid ? expLit(pixCode[1:0], expPhase) : 1'b0);
  endtask

  task automatic advance();
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    expPhase = (expPhase + 1) % 3;
  endtask

  // R1: reset phase is 0
  task automatic t_reset();
    drive(4'b0101, 1'b1);
    chk("R1", redOn, 1'b1);
    chk("R1", greenOn, 1'b1);
    drive(4'b0000, 1'b1);
    chk("R1", redOn, 1'b0);
    chk("R1", greenOn, 1'b0);
  endtask

  // R2..R6: every code in every phase
  task automatic t_decode_all();
    for (int p = 0; p < 3; p++) begin
      for (int c = 0; c < 16; c++) begin
        drive(4'(c), 1'b1);
        if (c[3:2] == 2'b00 || c[1:0] == 2'b00) checkPix("R3");
        else if (c[3:2] == 2'b11)               checkPix("R4");
        else if (c[3:2] == 2'b01)               checkPix("R5");
        else                                    checkPix("R6");
      end
      // R2: colours separate
      drive(4'b1100, 1'b1);
      chk("R2", redOn, 1'b1);
      chk("R2", greenOn, 1'b0);
      drive(4'b0011, 1'b1);
      chk("R2", redOn, 1'b0);
      chk("R2", greenOn, 1'b1);
      advance();
    end
  endtask

  // R7: hold without strobe, wrap after three strobes
  task automatic t_hold_wrap();
    advance();
    for (int i = 0; i < 5; i++) begin
      drive(4'b1001, 1'b1);
      checkPix("R7");
    end
    advance();
    advance();
    advance();
    drive(4'b1001, 1'b1);
    checkPix("R7");
    while (expPhase != 0) advance();
    drive(4'b0101, 1'b1);
    chk("R7", redOn, 1'b1);
  endtask

  // R8: masking, and phase still moves while masked
  task automatic t_valid_mask();
    for (int c = 0; c < 16; c++) begin
      drive(4'(c), 1'b0);
      chk("R8", redOn, 1'b0);
      chk("R8", greenOn, 1'b0);
    end
    @(negedge clk);
    frameStart = 1'b1;
    pixCode    = 4'b1111;
    pixValid   = 1'b0;
    @(negedge clk);
    frameStart = 1'b0;
    expPhase = (expPhase + 1) % 3;
    drive(4'b0101, 1'b1);
    checkPix("R8");
    drive(4'b1010, 1'b1);
    checkPix("R8");
  endtask

  // R9: strobe and decode in the same cycle
  task automatic t_same_cycle();
    while (expPhase != 0) advance();
    @(negedge clk);
    frameStart = 1'b1;
    pixCode    = 4'b0100;
    pixValid   = 1'b1;
    #1;
    chk("R9", redOn, 1'b1);
    @(negedge clk);
    frameStart = 1'b0;
    expPhase = 1;
    #1;
    chk("R9", redOn, 1'b0);
  endtask

  // R10: lit count over three consecutive frames
  task automatic t_window();
    for (int rep = 0; rep < 3; rep++) begin
      for (int lv = 0; lv < 4; lv++) begin
        int redCnt = 0;
        int grnCnt = 0;
        for (int f = 0; f < 3; f++) begin
          drive({2'(lv), 2'(lv)}, 1'b1);
          redCnt += int'(redOn);
          grnCnt += int'(greenOn);
          advance();
        end
        total++;
        if (redCnt != lv) begin
          bad++;
          $display("FAIL R10 red level=%0d actual=%0d expected=%0d", lv, redCnt, lv);
        end
        total++;
        if (grnCnt != lv) begin
          bad++;
          $display("FAIL R10 green level=%0d actual=%0d expected=%0d", lv, grnCnt, lv);
        end
      end
      advance();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_decode_all();
    t_hold_wrap();
    t_valid_mask();
    t_same_cycle();
    t_window();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule